// File: doc/BRIEF.md
# Multi-Stream Pseudorandom Noise Source with Decaying Level

This block feeds the per-neuron noise terms of a recurrent-network convolutional decoder. One 31-bit maximal-length linear feedback shift register runs freely. Each of the 17 outputs, one per neuron, is a fixed XOR of two of its stages. Such an XOR is a phase-shifted copy of the same maximal-length sequence, so every stream is balanced and has low correlation with the others. One register serves all outputs.

Each stream drives a level gate of four binary-weighted branch pairs. A level bit that is clear drives its pair with opposite constants, so the pair cancels. A level bit that is set drives both branches with the noise bit. The sum is a signed word of magnitude equal to the current level. A scheduler loads a start level at the beginning of each decoding step. It then lowers the level by one every programmed number of clocks and holds it at zero. The decoder core adds the signed words, one per neuron, to its neuron sums.

Top module: `noise_bank`

## Requirements
- R1: While `rst_n` is low, and until the block starts, `level`, `noise_bits` and every `noise_vals` word read zero. Internal operation starts on the third rising clock edge after `rst_n` goes high, because the reset release passes through two synchronizing flops.
- R2: The shift register holds 31 bits and is reset to seed 1. On each running clock edge it shifts toward the high end, and the new bit 0 is state[30] XOR state[27]. Its state is never all zero.
- R3: Stream k (k = 0..16) is state[k mod 31] XOR state[(k+13) mod 31], taken from the state before the edge and registered into `noise_bits[k]` on that edge.
- R4: Over 4096 consecutive running samples, every pair of distinct streams agrees in at least 25% and at most 75% of the samples.
- R5: Word k occupies `noise_vals[5k+4:5k]` in 5-bit two's complement. It equals +L when `noise_bits[k]` is 1 and −L when it is 0. L is the `level` value of the cycle before, and the word is registered on the same edge as `noise_bits`.
- R6: A clock edge with `step_start` high loads `start_level` into `level`. After that the level stays for N clocks and then drops by exactly one. N is `decay_period`, and a value of 0 counts as 1.
- R7: Once `level` reaches zero it stays at zero until the next `step_start`.
- R8: A `step_start` while the level is still decaying reloads the level at once and restarts the N-clock interval.
- R9: While the level is zero, every `noise_vals` word is zero, whatever the noise bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_start | input | 1 | Start of a decoding step; loads the level |
| start_level | input | 4 | Level loaded on `step_start` |
| decay_period | input | 16 | Clocks per level decrement (0 counts as 1) |
| level | output | 4 | Current noise level |
| noise_bits | output | 17 | Registered raw noise bit per stream |
| noise_vals | output | 85 | Registered signed noise word per stream, 5 bits each |

## Verification
On every cycle the assertions check four things: the shift register never holds zero, a start loads the level, the level moves down by at most one and sticks at zero, and each signed word matches its noise bit and the previous level. Only the bench scenarios show the exact tap positions and feedback polynomial. The same holds for the exact N-clock spacing of decrements, including the zero-period case, and for a restart in the middle of a decay. The pairwise agreement rate is a statistical property and is likewise measured only by the bench over its 4096-sample window.

// File: rtl/noise_pkg.sv
package noise_pkg;

  // Stage index used by a stream: (k + offset) folded into the register length.
  function automatic int stage_index(input int k, input int offset, input int width);
    return (k + offset) % width;
  endfunction

  // Effective decrement period: zero behaves as one.
  function automatic int unsigned eff_period(input int unsigned p);
    return (p == 0) ? 1 : p;
  endfunction

endpackage

// File: rtl/lfsr_core.sv
module lfsr_core #(
  parameter int          WIDTH = 31,
  parameter int          FB_A  = 30,
  parameter int          FB_B  = 27,
  parameter logic [30:0] SEED  = 31'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] state
);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  always_comb begin
    state_d = {state_q[WIDTH-2:0], state_q[FB_A] ^ state_q[FB_B]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIDTH'(SEED);
    end else if (en) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/level_sched.sv
module level_sched #(
  parameter int LVL_W = 4,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LVL_W-1:0] start_lvl,
  input  logic [PER_W-1:0] period,
  output logic [LVL_W-1:0] level
);

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [PER_W-1:0] div_q, div_d;
  logic [PER_W-1:0] per_eff;
  logic             interval_done;
  logic             upd_en;

  always_comb begin
    per_eff       = (period == '0) ? PER_W'(1) : period;
    interval_done = (div_q >= per_eff - PER_W'(1));
    upd_en        = load | (lvl_q != '0);
    lvl_d         = lvl_q;
    div_d         = div_q;
    if (load) begin
      lvl_d = start_lvl;
      div_d = '0;
    end else if (lvl_q != '0) begin
      if (interval_done) begin
        lvl_d = lvl_q - LVL_W'(1);
        div_d = '0;
      end else begin
        div_d = div_q + PER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      div_q <= '0;
    end else if (upd_en) begin
      lvl_q <= lvl_d;
      div_q <= div_d;
    end
  end

  assign level = lvl_q;

endmodule

// File: rtl/level_gate.sv
module level_gate #(
  parameter int LVL_W = 4,
  parameter int VAL_W = LVL_W + 1
) (
  input  logic             noise_bit,
  input  logic [LVL_W-1:0] lvl,
  output logic [VAL_W-1:0] val
);

  logic [LVL_W-1:0] br_a;
  logic [LVL_W-1:0] br_b;

  // Each weight has a pair of branches: gated off -> (1,0) cancels,
  // gated on -> both carry the noise bit.
  for (genvar i = 0; i < LVL_W; i++) begin : g_pair
    assign br_a[i] = lvl[i] ? noise_bit : 1'b1;
    assign br_b[i] = lvl[i] ? noise_bit : 1'b0;
  end

  always_comb begin
    val = '0;
    for (int i = 0; i < LVL_W; i++) begin
      if (br_a[i] & br_b[i]) begin
        val = val + (VAL_W'(1) << i);
      end else if (!br_a[i] & !br_b[i]) begin
        val = val - (VAL_W'(1) << i);
      end
    end
  end

endmodule

// File: rtl/noise_bank.sv
module noise_bank #(
  parameter int          NUM_OUT     = 17,
  parameter int          LFSR_W      = 31,
  parameter int          FB_A        = 30,
  parameter int          FB_B        = 27,
  parameter int          PARTNER_OFS = 13,
  parameter logic [30:0] SEED        = 31'h1,
  parameter int          LVL_W       = 4,
  parameter int          PER_W       = 16,
  localparam int         VAL_W       = LVL_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_start,
  input  logic [LVL_W-1:0]         start_level,
  input  logic [PER_W-1:0]         decay_period,
  output logic [LVL_W-1:0]         level,
  output logic [NUM_OUT-1:0]       noise_bits,
  output logic [NUM_OUT*VAL_W-1:0] noise_vals
);

  import noise_pkg::*;

  logic [1:0]               rst_pipe;
  logic                     rst_sn;
  logic [LFSR_W-1:0]        lfsr_q;
  logic [LVL_W-1:0]         level_cur;
  logic [NUM_OUT-1:0]       tap_bits;
  logic [NUM_OUT*VAL_W-1:0] gate_vals;
  logic [NUM_OUT-1:0]       bits_q, bits_d;
  logic [NUM_OUT*VAL_W-1:0] vals_q, vals_d;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[1];

  lfsr_core #(
    .WIDTH (LFSR_W),
    .FB_A  (FB_A),
    .FB_B  (FB_B),
    .SEED  (SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_sn),
    .en    (1'b1),
    .state (lfsr_q)
  );

  level_sched #(
    .LVL_W (LVL_W),
    .PER_W (PER_W)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load      (step_start),
    .start_lvl (start_level),
    .period    (decay_period),
    .level     (level_cur)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_stream
    localparam int TA = stage_index(k, 0, LFSR_W);
    localparam int TB = stage_index(k, PARTNER_OFS, LFSR_W);

    assign tap_bits[k] = lfsr_q[TA] ^ lfsr_q[TB];

    level_gate #(
      .LVL_W (LVL_W),
      .VAL_W (VAL_W)
    ) u_gate (
      .noise_bit (tap_bits[k]),
      .lvl       (level_cur),
      .val       (gate_vals[k*VAL_W +: VAL_W])
    );
  end

  always_comb begin
    bits_d = tap_bits;
    vals_d = gate_vals;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      bits_q <= '0;
      vals_q <= '0;
    end else begin
      bits_q <= bits_d;
      vals_q <= vals_d;
    end
  end

  assign level      = level_cur;
  assign noise_bits = bits_q;
  assign noise_vals = vals_q;

endmodule

// File: rtl/noise_bank_chk.sv
module noise_bank_chk #(
  parameter int NUM_OUT = 17,
  parameter int LFSR_W  = 31,
  parameter int LVL_W   = 4,
  localparam int VAL_W  = LVL_W + 1
) (
  input logic                     clk,
  input logic                     rst_sn,
  input logic                     step_start,
  input logic [LVL_W-1:0]         start_level,
  input logic [LVL_W-1:0]         level,
  input logic [LFSR_W-1:0]        lfsr_state,
  input logic [NUM_OUT-1:0]       noise_bits,
  input logic [NUM_OUT*VAL_W-1:0] noise_vals
);

  logic [LVL_W-1:0] lvl_prev;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      lvl_prev <= '0;
    end else begin
      lvl_prev <= level;
    end
  end

  // R2: register state never collapses to zero
  a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_sn)
    lfsr_state != '0);

  // R6: a start loads the requested level
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_sn)
    step_start |=> (level == $past(start_level)));

  // R6: without a start the level holds or drops by exactly one
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_sn)
    (!step_start && level != '0) |=>
      (level == $past(level) || ((LVL_W+1)'(level) + (LVL_W+1)'(1)) == (LVL_W+1)'($past(level))));

  // R7: zero is sticky until the next start
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_sn)
    (!step_start && level == '0) |=> (level == '0));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    // R5 / R9: signed word follows noise bit and previous level
    a_r5_signed_word: assert property (@(posedge clk) disable iff (!rst_sn)
      noise_vals[k*VAL_W +: VAL_W] ==
        (noise_bits[k] ? VAL_W'(lvl_prev) : (VAL_W'(0) - VAL_W'(lvl_prev))));
  end

endmodule

bind noise_bank noise_bank_chk #(
  .NUM_OUT (NUM_OUT),
  .LFSR_W  (LFSR_W),
  .LVL_W   (LVL_W)
) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .step_start  (step_start),
  .start_level (start_level),
  .level       (level),
  .lfsr_state  (lfsr_q),
  .noise_bits  (noise_bits),
  .noise_vals  (noise_vals)
);

// File: tb/noise_bank_tb.sv
module noise_bank_tb;

  localparam int NUM_OUT = 17;
  localparam int LW      = 31;
  localparam int LVL_W   = 4;
  localparam int PER_W   = 16;
  localparam int VAL_W   = LVL_W + 1;
  localparam int WINDOW  = 4096;

  logic                     clk;
  logic                     rst_n;
  logic                     step_start;
  logic [LVL_W-1:0]         start_level;
  logic [PER_W-1:0]         decay_period;
  logic [LVL_W-1:0]         level;
  logic [NUM_OUT-1:0]       noise_bits;
  logic [NUM_OUT*VAL_W-1:0] noise_vals;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  noise_bank u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_start   (step_start),
    .start_level  (start_level),
    .decay_period (decay_period),
    .level        (level),
    .noise_bits   (noise_bits),
    .noise_vals   (noise_vals)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---- reference stream model built from R1..R3 ----
  logic              m_s1, m_s2;
  logic [LW-1:0]     m_state;
  logic [NUM_OUT-1:0] m_bits;

  function automatic logic [NUM_OUT-1:0] ref_taps(input logic [LW-1:0] s);
    logic [NUM_OUT-1:0] r;
    for (int k = 0; k < NUM_OUT; k++) r[k] = s[k % LW] ^ s[(k + 13) % LW];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1    <= 1'b0;
      m_s2    <= 1'b0;
      m_state <= 31'h1;
      m_bits  <= '0;
    end else begin
      m_s1 <= 1'b1;
      m_s2 <= m_s1;
      if (m_s2) begin
        m_bits  <= ref_taps(m_state);
        m_state <= {m_state[LW-2:0], m_state[30] ^ m_state[27]};
      end
    end
  end

  // ---- scoreboard ----
  typedef struct {
    int lvl;
    int mag;
    int req;
  } exp_t;

  exp_t sb_q[$];
  int   prev_lvl = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int exp_level(input int s, input int n, input int c);
    int nn;
    int v;
    nn = (n == 0) ? 1 : n;
    v  = s - c / nn;
    return (v < 0) ? 0 : v;
  endfunction

  // Driver: issues a step and queues the level and word magnitude per cycle.
  task automatic run_step(input int s, input int n, input int cycles, input int req);
    exp_t e;
    @(negedge clk);
    step_start   = 1'b1;
    start_level  = LVL_W'(s);
    decay_period = PER_W'(n);
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      #1;
      step_start = 1'b0;
      e.lvl = exp_level(s, n, c);
      e.mag = prev_lvl;
      e.req = req;
      prev_lvl = e.lvl;
      sb_q.push_back(e);
    end
    @(negedge clk);
  endtask

  // Monitor
  int agree [NUM_OUT][NUM_OUT];
  int samples = 0;

  always @(negedge clk) begin
    if (m_s2 && rst_n) begin
      // R3: tap positions and register feedback
      check(noise_bits == m_bits, "R3", int'(noise_bits), int'(m_bits), "noise_bits");
      if (samples < WINDOW) begin
        for (int a = 0; a < NUM_OUT; a++)
          for (int b = a + 1; b < NUM_OUT; b++)
            if (noise_bits[a] == noise_bits[b]) agree[a][b]++;
        samples++;
      end
    end
    if (sb_q.size() > 0) begin
      exp_t e;
      string tag;
      e = sb_q.pop_front();
      tag = (e.req == 8) ? "R8" : (e.req == 7) ? "R7" : "R6";
      check(int'(level) == e.lvl, tag, int'(level), e.lvl, "level");
      for (int k = 0; k < NUM_OUT; k++) begin
        logic [VAL_W-1:0] ev;
        ev = noise_bits[k] ? VAL_W'(e.mag) : (VAL_W'(0) - VAL_W'(e.mag));
        if (e.mag == 0)
          check(noise_vals[k*VAL_W +: VAL_W] == ev, "R9", int'(noise_vals[k*VAL_W +: VAL_W]), int'(ev), "zero-level word");
        else
          check(noise_vals[k*VAL_W +: VAL_W] == ev, "R5", int'(noise_vals[k*VAL_W +: VAL_W]), int'(ev), "signed word");
      end
    end
  end

  // Watchdog
  initial begin
    #(150000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NUM_OUT; a++)
      for (int b = 0; b < NUM_OUT; b++) agree[a][b] = 0;
    rst_n        = 1'b0;
    step_start   = 1'b0;
    start_level  = '0;
    decay_period = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(level == '0, "R1", int'(level), 0, "level in reset");
    check(noise_bits == '0, "R1", int'(noise_bits), 0, "noise_bits in reset");
    check(noise_vals == '0, "R1", 0, 0, "noise_vals in reset");

    rst_n = 1'b1;
    @(negedge clk);
    // R1: still idle before synchronized release completes
    check(noise_bits == '0, "R1", int'(noise_bits), 0, "noise_bits during release");
    repeat (4) @(negedge clk);

    // R6, R7: full decay from 15 with period 3, then hold at zero
    run_step(15, 3, 15 * 3 + 8, 7);
    // R6: period zero counts as one
    run_step(9, 0, 12, 6);
    // R8: restart in the middle of a decay
    run_step(12, 5, 13, 6);
    run_step(4, 2, 12, 8);
    // R9: start level zero keeps all words at zero
    run_step(0, 7, 6, 7);
    // R5: small odd level, long period
    run_step(5, 4, 24, 6);

    while (samples < WINDOW) @(negedge clk);
    // R4: pairwise agreement within 25%..75%
    for (int a = 0; a < NUM_OUT; a++)
      for (int b = a + 1; b < NUM_OUT; b++)
        check(agree[a][b] >= WINDOW / 4 && agree[a][b] <= 3 * WINDOW / 4, "R4",
              agree[a][b], WINDOW / 2, $sformatf("agreement %0d/%0d", a, b));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule